// File: doc/BRIEF.md
# Mirrored Memory with Per-Lane Parity Fallback

This block is a synchronous single-port memory with a mode input. In conventional mode it behaves as one array addressed by the full address, and data is stored and returned exactly as written. In error-correcting mode the storage is used as two mirrored copies of half the capacity. The top address bit is ignored, and every write lands in both copies. On a read, each 9-bit lane of the primary copy is checked for odd parity on its own. A lane that passes is returned. A lane that fails is replaced by the same lane from the secondary copy, and a per-lane flag reports the substitution.

Writes follow a late-write protocol: the write data arrives on the cycle after the write command. A one-entry pending-write register holds the address until then. A read that targets the address of that pending write is served from the incoming write data, which is returned without any parity check. Read results are registered. The memory is split into two half-depth banks so that each bank maps onto block RAM with one write port and one read port.

Top module: `mirror_parity_mem`

## Requirements
- R1: While reset is held, and on the first cycle after it, `rd_valid` is 0 and `rd_alt` is all zeros.
- R2: If a read command (`cmd_valid`=1, `cmd_write`=0) is sampled on edge N, `rd_valid`, `rd_data` and `rd_alt` carry its result after edge N+1. A cycle with no read command leaves `rd_valid` at 0 one edge later.
- R3: Write data for a write command sampled on edge N is taken from `wr_data` on edge N+1. Any read sampled after edge N+1 returns that data.
- R4: In conventional mode (`ec_mode`=0) the full `ADDR_W`-bit address selects the word. Addresses that differ only in the top bit hold independent data.
- R5: In conventional mode a read returns the stored word unchanged, even if its lanes have even parity, and `rd_alt` is 0.
- R6: In error-correcting mode (`ec_mode`=1) the top address bit is ignored. Addresses that differ only in that bit read and write the same word.
- R7: In error-correcting mode a write stores its data in both copies. The primary copy is the conventional lower half (top bit 0) and the secondary copy is the upper half (top bit 1), so a later conventional read of either half returns the data.
- R8: Lane i is bits [9i+8:9i] of the word. In an error-correcting read, a primary lane whose 9 bits have odd parity is output with `rd_alt[i]`=0. A primary lane with even parity is replaced by the secondary lane i and `rd_alt[i]`=1. Each lane decides independently.
- R9: A secondary lane is never parity-checked. It is output as stored, even if its own parity is even.
- R10: A read sampled on the same edge as the data of a pending write to the same address (the full address in conventional mode, the address without its top bit in error-correcting mode) returns that `wr_data` unchanged with `rd_alt` all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ec_mode | input | 1 | 1 = mirrored error-correcting mode, 0 = conventional mode |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_write | input | 1 | 1 = write command, 0 = read command |
| cmd_addr | input | ADDR_W | Word address of the command |
| wr_data | input | LANES*9 | Write data, presented the cycle after its write command |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | LANES*9 | Read result word |
| rd_alt | output | LANES | Per lane, 1 when the secondary copy supplied that lane |

## Verification
A read command driven before edge N is compared at the falling edge after edge N+1. The bench queues each expected result two iterations deep and checks it at that falling edge, including the cycles that must show `rd_valid` low. Write data is driven one iteration after its command and enters the reference model on that same iteration. A read issued in that iteration to the matching address therefore expects the raw bypassed word. The primary copy is corrupted only through conventional-mode writes to the lower half, so each substitution case is set up through the ports alone.

// File: rtl/mirror_parity_pkg.sv
package mirror_parity_pkg;
  localparam int LANE_W = 9;

  typedef logic [LANE_W-1:0] lane_t;

  // A lane is healthy when its bits, parity bit included, have odd parity.
  function automatic logic lane_odd(input lane_t v);
    return ^v;
  endfunction
endpackage

// File: rtl/mpm_bank.sv
module mpm_bank #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mpm_lane_sel.sv
module mpm_lane_sel
  import mirror_parity_pkg::*;
(
  input  logic  ec_chk,
  input  logic  hi_sel,
  input  logic  byp,
  input  lane_t prim,
  input  lane_t sec,
  input  lane_t bypd,
  output lane_t lane_o,
  output logic  alt_o
);
  always_comb begin
    lane_o = prim;
    alt_o  = 1'b0;
    if (byp) begin
      lane_o = bypd;
    end else if (ec_chk) begin
      if (!lane_odd(prim)) begin
        lane_o = sec;
        alt_o  = 1'b1;
      end
    end else if (hi_sel) begin
      lane_o = sec;
    end
  end
endmodule

// File: rtl/mirror_parity_mem.sv
module mirror_parity_mem
  import mirror_parity_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ec_mode,
  input  logic                      cmd_valid,
  input  logic                      cmd_write,
  input  logic [ADDR_W-1:0]         cmd_addr,
  input  logic [LANES*LANE_W-1:0]   wr_data,
  output logic                      rd_valid,
  output logic [LANES*LANE_W-1:0]   rd_data,
  output logic [LANES-1:0]          rd_alt
);
  localparam int DATA_W  = LANES * LANE_W;
  localparam int BANK_AW = ADDR_W - 1;
  localparam int TOP     = ADDR_W - 1;

  logic rd_cmd, wr_cmd;
  assign rd_cmd = cmd_valid && !cmd_write;
  assign wr_cmd = cmd_valid && cmd_write;

  // Pending-write register: address waits one cycle for its data.
  logic              pend_valid, pend_ec;
  logic [ADDR_W-1:0] pend_addr;

  always_ff @(posedge clk) begin
    if (rst) pend_valid <= 1'b0;
    else     pend_valid <= wr_cmd;
    pend_ec   <= ec_mode;
    pend_addr <= cmd_addr;
  end

  // Bank 0 = lower half / primary copy, bank 1 = upper half / secondary copy.
  logic [1:0]        bank_we;
  logic [DATA_W-1:0] bank_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign bank_we[b] = pend_valid && (pend_ec || (pend_addr[TOP] == 1'(b)));
    mpm_bank #(.ADDR_W(BANK_AW), .DATA_W(DATA_W)) bank_i (
      .clk  (clk),
      .we   (bank_we[b]),
      .waddr(pend_addr[BANK_AW-1:0]),
      .wdata(wr_data),
      .re   (rd_cmd),
      .raddr(cmd_addr[BANK_AW-1:0]),
      .rdata(bank_q[b])
    );
  end

  logic byp_hit;
  assign byp_hit = pend_valid &&
                   (ec_mode ? (pend_addr[BANK_AW-1:0] == cmd_addr[BANK_AW-1:0])
                            : (pend_addr == cmd_addr));

  // Stage 1: array read in flight.
  logic              s1_valid, s1_ec, s1_hi, s1_byp;
  logic [DATA_W-1:0] s1_bdata;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= rd_cmd;
    s1_ec    <= ec_mode;
    s1_hi    <= cmd_addr[TOP];
    s1_byp   <= byp_hit;
    s1_bdata <= wr_data;
  end

  logic [DATA_W-1:0] sel_data;
  logic [LANES-1:0]  sel_alt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    mpm_lane_sel lane_i (
      .ec_chk(s1_ec),
      .hi_sel(s1_hi),
      .byp   (s1_byp),
      .prim  (bank_q[0][i*LANE_W +: LANE_W]),
      .sec   (bank_q[1][i*LANE_W +: LANE_W]),
      .bypd  (s1_bdata[i*LANE_W +: LANE_W]),
      .lane_o(sel_data[i*LANE_W +: LANE_W]),
      .alt_o (sel_alt[i])
    );

    // R8: a lane kept from the primary copy in a checked read has odd parity.
    a_r8_kept_lane_odd: assert property (@(posedge clk) disable iff (rst)
      (rd_cmd && ec_mode && !byp_hit) |-> ##2 (rd_alt[i] || ^rd_data[i*LANE_W +: LANE_W]));
  end

  // Output register.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_alt   <= '0;
    end else begin
      rd_valid <= s1_valid;
      rd_alt   <= s1_valid ? sel_alt : '0;
      if (s1_valid) rd_data <= sel_data;
    end
  end

  // R1: outputs quiet after reset.
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rd_valid && rd_alt == '0));

  // R2: every read yields a result two edges on; other cycles yield none.
  a_r2_read_result: assert property (@(posedge clk) disable iff (rst)
    rd_cmd |-> ##2 rd_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !rd_cmd |-> ##2 !rd_valid);

  // R3: a write command always commits to at least one bank on the next edge.
  a_r3_write_commits: assert property (@(posedge clk) disable iff (rst)
    wr_cmd |=> (bank_we != 2'b00));

  // R7: in mirrored mode both banks commit together.
  a_r7_both_banks: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && ec_mode) |=> (bank_we == 2'b11));

  // R5: conventional reads never substitute.
  a_r5_conv_no_alt: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && !ec_mode) |-> ##2 (rd_alt == '0));

  // R10: a bypassed read returns the incoming write data untouched.
  a_r10_bypass_raw: assert property (@(posedge clk) disable iff (rst)
    (rd_cmd && byp_hit) |-> ##2 (rd_alt == '0 && rd_data == $past(wr_data, 2)));
endmodule

// File: tb/mirror_parity_mem_tb_top.sv
module mirror_parity_mem_tb_top;
  localparam int AW   = 8;
  localparam int LN   = 4;
  localparam int DW   = LN * 9;
  localparam int HALF = 1 << (AW - 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst, ec_mode, cmd_valid, cmd_write;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] wr_data;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [LN-1:0] rd_alt;

  mirror_parity_mem #(.ADDR_W(AW), .LANES(LN)) dut_i (
    .clk(clk), .rst(rst), .ec_mode(ec_mode), .cmd_valid(cmd_valid),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_alt(rd_alt)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [DW-1:0] m0 [HALF];
  logic [DW-1:0] m1 [HALF];

  bit            ea_v, eb_v;
  logic [DW-1:0] ea_d, eb_d;
  logic [LN-1:0] ea_alt, eb_alt;
  string         ea_tag, eb_tag;

  bit            pw_v, pw_ec;
  logic [AW-1:0] pw_a;
  logic [DW-1:0] pw_d;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rword(bit good);
    logic [DW-1:0] w;
    for (int i = 0; i < LN; i++) begin
      logic [31:0] r;
      logic [7:0]  b;
      r = $urandom;
      b = r[7:0];
      w[i*9 +: 9] = {good ? ~^b : r[8], b};
    end
    return w;
  endfunction

  function automatic logic [DW-1:0] spoil(logic [DW-1:0] w, logic [LN-1:0] mask);
    for (int i = 0; i < LN; i++)
      if (mask[i]) w[i*9] = ~w[i*9];
    return w;
  endfunction

  // One bench cycle: check the result due now, then drive the next command.
  task automatic cyc(bit v, bit w, logic [AW-1:0] a, bit mode, logic [DW-1:0] d, string tag);
    logic [AW-2:0] lo;
    @(negedge clk);
    check(eb_v ? eb_tag : "R2", "rd_valid", 64'(rd_valid), 64'(eb_v));
    if (eb_v) begin
      check(eb_tag, "rd_data", 64'(rd_data), 64'(eb_d));
      check(eb_tag, "rd_alt", 64'(rd_alt), 64'(eb_alt));
    end
    eb_v = ea_v; eb_d = ea_d; eb_alt = ea_alt; eb_tag = ea_tag;

    ec_mode   = mode;
    cmd_valid = v;
    cmd_write = w;
    cmd_addr  = a;
    wr_data   = pw_v ? pw_d : '0;

    lo   = a[AW-2:0];
    ea_v = v && !w;
    ea_tag = tag;
    ea_alt = '0;
    ea_d   = '0;
    if (ea_v) begin
      if (pw_v && (mode ? (pw_a[AW-2:0] == lo) : (pw_a == a))) begin
        ea_d = pw_d;
      end else if (mode) begin
        for (int i = 0; i < LN; i++) begin
          if (^m0[lo][i*9 +: 9]) ea_d[i*9 +: 9] = m0[lo][i*9 +: 9];
          else begin
            ea_d[i*9 +: 9] = m1[lo][i*9 +: 9];
            ea_alt[i] = 1'b1;
          end
        end
      end else begin
        ea_d = a[AW-1] ? m1[lo] : m0[lo];
      end
    end

    if (pw_v) begin
      if (pw_ec) begin
        m0[pw_a[AW-2:0]] = pw_d;
        m1[pw_a[AW-2:0]] = pw_d;
      end else if (pw_a[AW-1]) m1[pw_a[AW-2:0]] = pw_d;
      else                     m0[pw_a[AW-2:0]] = pw_d;
    end
    pw_v  = v && w;
    pw_a  = a;
    pw_ec = mode;
    pw_d  = d;
  endtask

  task automatic wr(logic [AW-1:0] a, bit mode, logic [DW-1:0] d);
    cyc(1'b1, 1'b1, a, mode, d, "R3");
  endtask
  task automatic rd(logic [AW-1:0] a, bit mode, string tag);
    cyc(1'b1, 1'b0, a, mode, '0, tag);
  endtask
  task automatic idle(bit mode);
    cyc(1'b0, 1'b0, '0, mode, '0, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] g, p, s;
    void'($urandom(32'd1234));
    rst = 1'b1; ec_mode = 1'b0; cmd_valid = 1'b0; cmd_write = 1'b0;
    cmd_addr = '0; wr_data = '0;
    ea_v = 0; eb_v = 0; pw_v = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "rd_valid in reset", 64'(rd_valid), 64'(0));
    check("R1", "rd_alt in reset", 64'(rd_alt), 64'(0));
    rst = 1'b0;
    @(negedge clk);
    check("R1", "rd_valid after reset", 64'(rd_valid), 64'(0));
    check("R1", "rd_alt after reset", 64'(rd_alt), 64'(0));

    // Fill every word in conventional mode with healthy data (R4).
    for (int a = 0; a < 2 * HALF; a++) wr(AW'(a), 1'b0, rword(1'b1));
    for (int a = 0; a < 16; a++) rd(AW'(a * 17), 1'b0, "R4");

    // R4: halves independent in conventional mode.
    wr(8'h07, 1'b0, rword(1'b1)); wr(8'h87, 1'b0, rword(1'b1)); idle(1'b0);
    rd(8'h07, 1'b0, "R4"); rd(8'h87, 1'b0, "R4");

    // R5: even-parity word returned unchanged in conventional mode.
    wr(8'h05, 1'b0, spoil(rword(1'b1), 4'b1111)); idle(1'b0);
    rd(8'h05, 1'b0, "R5");

    // R3: late write lands, then back-to-back reads (R2).
    wr(8'h50, 1'b0, rword(1'b1)); wr(8'h51, 1'b0, rword(1'b1));
    rd(8'h50, 1'b0, "R3"); rd(8'h51, 1'b0, "R3"); rd(8'h50, 1'b0, "R2");

    // R7: mirrored write reaches both halves.
    wr(8'h10, 1'b1, rword(1'b1)); idle(1'b1);
    rd(8'h10, 1'b0, "R7"); rd(8'h90, 1'b0, "R7");

    // R6: top bit ignored in error-correcting mode.
    rd(8'h90, 1'b1, "R6");
    wr(8'h91, 1'b1, rword(1'b1)); idle(1'b1);
    rd(8'h11, 1'b1, "R6");

    // R8: lanes 0 and 2 of the primary copy spoiled, lanes 1 and 3 replaced by other healthy data.
    g = rword(1'b1);
    wr(8'h20, 1'b1, g); idle(1'b1);
    p = spoil(rword(1'b1), 4'b0101);
    wr(8'h20, 1'b0, p); idle(1'b0);
    rd(8'h20, 1'b1, "R8"); rd(8'hA0, 1'b1, "R8");

    // R9: secondary lanes with even parity still used, unchecked.
    s = spoil(rword(1'b1), 4'b1111);
    wr(8'hA5, 1'b0, s);
    wr(8'h25, 1'b0, spoil(rword(1'b1), 4'b0011)); idle(1'b0);
    rd(8'h25, 1'b1, "R9");

    // R10: bypass returns raw data, aliased address in error-correcting mode.
    wr(8'h30, 1'b1, spoil(rword(1'b1), 4'b1111));
    rd(8'hB0, 1'b1, "R10");
    rd(8'h30, 1'b1, "R9");
    wr(8'h44, 1'b0, spoil(rword(1'b1), 4'b1010));
    rd(8'h44, 1'b0, "R10");
    wr(8'h45, 1'b0, rword(1'b1));
    rd(8'hC5, 1'b0, "R4");

    // Random mix.
    for (int n = 0; n < 4000; n++) begin
      bit mode;
      int op;
      logic [AW-1:0] a;
      mode = ((n / 300) % 2) == 1;
      op = $urandom_range(0, 9);
      a = AW'($urandom_range(0, 15)) | (AW'($urandom_range(0, 1)) << (AW - 1));
      if (op < 4)      wr(a, mode, rword($urandom_range(0, 1) == 1));
      else if (op < 8) rd(a, mode, mode ? "R8" : "R4");
      else             idle(mode);
    end
    idle(1'b0); idle(1'b0); idle(1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule